// File: doc/BRIEF.md
# Serial Bus Slave Condition Detector

This block is the slave-side front end of a two-wire serial bus. The bus has one clock line and one shared open-drain data line. The block watches both lines through synchronizers. It treats any change of the data line while the clock is high as a bus condition rather than a data bit:

- A rising data edge with the clock high is a **bus release**.
- A falling data edge with the clock high is a **command**.

Each condition sets a sticky flag that software clears. Bits sampled on rising clock edges are shifted into a byte register, most significant bit first.

After a bus release, the first complete byte is compared with the slave's own address. When wake-up mode is on, the transfer interrupt fires only for a matching address byte. When wake-up mode is off, every completed byte interrupts.

The block can also hold the data line low to show "busy" to the master. A request to drop busy takes effect only at the next falling edge of the clock. Setting wake-up while that drop is pending cancels the drop. A status output lets software wait until the drop has completed.

Top module: `sbus_slave_det`

## Requirements
- R1: After reset, both condition flags, `xfer_irq_o`, `selected_o`, `sda_pull_o` and `drop_pending_o` are 0, and the address comparator waits for a bus release. A byte received before the first release is never treated as an address.
- R2: A low-to-high change on the data line while the clock stays high sets `rel_flag_o`. The flag remains set until a `rel_clr_i` pulse clears it.
- R3: A high-to-low change on the data line while the clock stays high sets `cmd_flag_o`. The flag remains set until a `cmd_clr_i` pulse clears it.
- R4: A bus condition discards any partly received byte, so bits that precede a condition never appear in `rx_byte_o`.
- R5: With `wake_en_i` = 1, the first byte after a release that equals `own_addr_i` produces exactly one `xfer_irq_o` pulse and sets `selected_o`.
- R6: With `wake_en_i` = 1, no interrupt is raised for a mismatching address byte, for bytes that follow the address byte, or for bytes received with no release before them. A mismatch leaves `selected_o` at 0.
- R7: With `wake_en_i` = 0, every completed 8-bit byte produces exactly one `xfer_irq_o` pulse.
- R8: A `busy_req_i` pulse asserts `sda_pull_o`. After a `busy_drop_i` pulse, `drop_pending_o` is 1 and `sda_pull_o` stays 1 until the clock line next falls.
- R9: At that falling clock edge, `sda_pull_o` and `drop_pending_o` both return to 0. Busy is never released in any other way except by reset.
- R10: A 0-to-1 change of `wake_en_i` while a drop is pending cancels the drop. The line stays pulled low through later clock falls until `busy_drop_i` is pulsed again.
- R11: `rx_byte_o` holds the eight bits sampled at successive rising clock edges, with the first bit in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line (asynchronous) |
| sda_in | input | 1 | Data line level (asynchronous) |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| own_addr_i | input | DATA_W | Programmed slave address |
| wake_en_i | input | 1 | Wake-up (address-gated interrupt) mode |
| busy_req_i | input | 1 | Pulse: start driving busy |
| busy_drop_i | input | 1 | Pulse: request busy release at next clock fall |
| rel_clr_i | input | 1 | Pulse: clear the bus-release flag |
| cmd_clr_i | input | 1 | Pulse: clear the command flag |
| rel_flag_o | output | 1 | Sticky bus-release flag |
| cmd_flag_o | output | 1 | Sticky command flag |
| xfer_irq_o | output | 1 | One-cycle transfer interrupt pulse |
| rx_byte_o | output | DATA_W | Last complete received byte |
| selected_o | output | 1 | Last address byte matched |
| drop_pending_o | output | 1 | Busy drop requested but not yet done |

## Verification
The bench builds the block with its defaults: an 8-bit byte and a two-stage synchronizer. Each bus phase lasts several system cycles, so both lines settle through the synchronizers before the next edge. The bench uses a model master. That master can cut a byte short with a condition, so discarding partial bytes can be checked. It can also hold the clock high or low at will, which opens the window between a drop request and the clock fall where the wake-up cancellation lives.

// File: rtl/sbsd_pkg.sv
package sbsd_pkg;

    typedef enum logic [1:0] {
        ADDR_WAIT  = 2'd0,
        ADDR_PHASE = 2'd1,
        DATA_PHASE = 2'd2
    } addr_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic bus_rel;
        logic bus_cmd;
    } line_evt_t;

    function automatic logic both_high(input logic cur, input logic prev);
        return cur & prev;
    endfunction

    function automatic logic went_up(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic logic went_down(input logic cur, input logic prev);
        return ~cur & prev;
    endfunction

endpackage

// File: rtl/sbsd_sync.sv
module sbsd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], async_i[g]};
            end
            assign sync_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sbsd_cond.sv
module sbsd_cond
    import sbsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output line_evt_t evt_o
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    logic clk_held_high;
    always_comb begin
        clk_held_high  = both_high(scl_s, scl_d);
        evt_o.scl_rise = went_up(scl_s, scl_d);
        evt_o.scl_fall = went_down(scl_s, scl_d);
        evt_o.bus_rel  = clk_held_high & went_up(sda_s, sda_d);
        evt_o.bus_cmd  = clk_held_high & went_down(sda_s, sda_d);
    end
endmodule

// File: rtl/sbsd_rx.sv
module sbsd_rx
    import sbsd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              bus_rel,
    input  logic              bus_cmd,
    input  logic              sda_bit,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              wake_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              irq,
    output logic              selected
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    addr_state_e       state_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] shifted;
    logic              byte_done;
    logic              addr_hit;

    always_comb begin
        shifted   = {shreg_q[DATA_W-2:0], sda_bit};
        byte_done = scl_rise && !bus_rel && !bus_cmd && (bitcnt_q == LAST_BIT);
        addr_hit  = (shifted == own_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ADDR_WAIT;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            rx_byte  <= '0;
            irq      <= 1'b0;
            selected <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (bus_rel) begin
                bitcnt_q <= '0;
                state_q  <= ADDR_PHASE;
                selected <= 1'b0;
            end else if (bus_cmd) begin
                bitcnt_q <= '0;
            end else if (scl_rise) begin
                shreg_q <= shifted;
                if (byte_done) begin
                    bitcnt_q <= '0;
                    rx_byte  <= shifted;
                    if (state_q == ADDR_PHASE) begin
                        state_q  <= DATA_PHASE;
                        selected <= addr_hit;
                        irq      <= wake_en ? addr_hit : 1'b1;
                    end else begin
                        irq <= !wake_en;
                    end
                end else begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbsd_busy.sv
module sbsd_busy (
    input  logic clk,
    input  logic rst,
    input  logic busy_req,
    input  logic busy_drop,
    input  logic wake_en,
    input  logic scl_fall,
    output logic pull,
    output logic pending
);
    logic wake_q;
    logic wake_rise;

    assign wake_rise = wake_en & ~wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q  <= 1'b0;
            pull    <= 1'b0;
            pending <= 1'b0;
        end else begin
            wake_q <= wake_en;
            if (busy_req) begin
                pull    <= 1'b1;
                pending <= 1'b0;
            end else if (wake_rise) begin
                pending <= 1'b0;
            end else if (pending && scl_fall) begin
                pull    <= 1'b0;
                pending <= 1'b0;
            end else if (busy_drop && pull) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbus_slave_det.sv
module sbus_slave_det
    import sbsd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_o,
    input  logic [DATA_W-1:0] own_addr_i,
    input  logic              wake_en_i,
    input  logic              busy_req_i,
    input  logic              busy_drop_i,
    input  logic              rel_clr_i,
    input  logic              cmd_clr_i,
    output logic              rel_flag_o,
    output logic              cmd_flag_o,
    output logic              xfer_irq_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              selected_o,
    output logic              drop_pending_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    line_evt_t        evt;

    sbsd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({scl_in, sda_in}),
        .sync_o  (lines_s)
    );

    sbsd_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt_o (evt)
    );

    sbsd_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .scl_rise (evt.scl_rise),
        .bus_rel  (evt.bus_rel),
        .bus_cmd  (evt.bus_cmd),
        .sda_bit  (lines_s[0]),
        .own_addr (own_addr_i),
        .wake_en  (wake_en_i),
        .rx_byte  (rx_byte_o),
        .irq      (xfer_irq_o),
        .selected (selected_o)
    );

    sbsd_busy u_busy (
        .clk       (clk),
        .rst       (rst),
        .busy_req  (busy_req_i),
        .busy_drop (busy_drop_i),
        .wake_en   (wake_en_i),
        .scl_fall  (evt.scl_fall),
        .pull      (sda_pull_o),
        .pending   (drop_pending_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_flag_o <= 1'b0;
            cmd_flag_o <= 1'b0;
        end else begin
            if (evt.bus_rel)    rel_flag_o <= 1'b1;
            else if (rel_clr_i) rel_flag_o <= 1'b0;
            if (evt.bus_cmd)    cmd_flag_o <= 1'b1;
            else if (cmd_clr_i) cmd_flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sbsd_chk.sv
module sbsd_chk (
    input logic clk,
    input logic rst,
    input logic wake_en_i,
    input logic rel_clr_i,
    input logic cmd_clr_i,
    input logic sda_pull_o,
    input logic drop_pending_o,
    input logic rel_flag_o,
    input logic cmd_flag_o,
    input logic xfer_irq_o,
    input logic selected_o
);
    logic seen_rst = 1'b0;
    always @(posedge clk) seen_rst <= rst;

    always @(negedge clk) begin
        if (seen_rst) begin
            assert_reset_state_R1: assert (!rel_flag_o && !cmd_flag_o && !sda_pull_o
                                           && !drop_pending_o && !xfer_irq_o && !selected_o);
        end
    end

    assert_rel_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        rel_flag_o && !rel_clr_i |=> rel_flag_o);

    assert_cmd_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_flag_o && !cmd_clr_i |=> cmd_flag_o);

    assert_wake_irq_sel_R5: assert property (@(posedge clk) disable iff (rst)
        xfer_irq_o && $past(wake_en_i) |-> selected_o);

    assert_pending_holds_R8: assert property (@(posedge clk) disable iff (rst)
        drop_pending_o |-> sda_pull_o);

    assert_release_path_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> $past(drop_pending_o));

    assert_wake_cancel_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_en_i) && drop_pending_o |=> sda_pull_o && !drop_pending_o);
endmodule

bind sbus_slave_det sbsd_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wake_en_i      (wake_en_i),
    .rel_clr_i      (rel_clr_i),
    .cmd_clr_i      (cmd_clr_i),
    .sda_pull_o     (sda_pull_o),
    .drop_pending_o (drop_pending_o),
    .rel_flag_o     (rel_flag_o),
    .cmd_flag_o     (cmd_flag_o),
    .xfer_irq_o     (xfer_irq_o),
    .selected_o     (selected_o)
);

// File: tb/tb_sbus_slave_det.sv
module tb_sbus_slave_det;
    localparam int DATA_W = 8;
    localparam int PH     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [DATA_W-1:0] own_addr = 8'hA6;
    logic wake_en = 1'b0, busy_req = 1'b0, busy_drop = 1'b0;
    logic rel_clr = 1'b0, cmd_clr = 1'b0;

    logic sda_pull, rel_flag, cmd_flag, xfer_irq, selected, drop_pending;
    logic [DATA_W-1:0] rx_byte;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    sbus_slave_det #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk            (clk),
        .rst            (rst),
        .scl_in         (scl_m),
        .sda_in         (sda_line),
        .sda_pull_o     (sda_pull),
        .own_addr_i     (own_addr),
        .wake_en_i      (wake_en),
        .busy_req_i     (busy_req),
        .busy_drop_i    (busy_drop),
        .rel_clr_i      (rel_clr),
        .cmd_clr_i      (cmd_clr),
        .rel_flag_o     (rel_flag),
        .cmd_flag_o     (cmd_flag),
        .xfer_irq_o     (xfer_irq),
        .rx_byte_o      (rx_byte),
        .selected_o     (selected),
        .drop_pending_o (drop_pending)
    );

    int n_checks = 0, n_errors = 0, irq_cnt = 0;
    bit done = 1'b0;

    always @(posedge clk) if (!rst && xfer_irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ph(); repeat (PH) @(negedge clk); endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; wait_ph();
    endtask

    task automatic send_bit(input logic b);
        scl_m = 1'b0; wait_ph(); sda_m = b; wait_ph(); scl_m = 1'b1; wait_ph();
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] v);
        for (int i = DATA_W - 1; i >= 0; i--) send_bit(v[i]);
        wait_ph();
    endtask

    task automatic bus_release();
        scl_m = 1'b0; wait_ph(); sda_m = 1'b0; wait_ph();
        scl_m = 1'b1; wait_ph(); sda_m = 1'b1; wait_ph();
    endtask

    task automatic bus_command();
        scl_m = 1'b0; wait_ph(); sda_m = 1'b1; wait_ph();
        scl_m = 1'b1; wait_ph(); sda_m = 1'b0; wait_ph();
    endtask

    function automatic int exp_irqs(input bit wk, input logic [DATA_W-1:0] first,
                                    input logic [DATA_W-1:0] addr, input int nbytes);
        if (wk) return (first == addr) ? 1 : 0;
        return nbytes;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic [DATA_W-1:0] v, first, last;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wait_ph();
        // R1 reset state
        chk("R1 rel_flag", rel_flag, 0);
        chk("R1 cmd_flag", cmd_flag, 0);
        chk("R1 pull", sda_pull, 0);
        chk("R1 pending", drop_pending, 0);
        chk("R1 selected", selected, 0);

        // R6 / R1: byte before any release is not an address in wake mode
        wake_en = 1'b1;
        base = irq_cnt;
        send_byte(own_addr);
        chk("R6 no irq before release", irq_cnt - base, 0);
        chk("R1 no selection before release", selected, 0);

        // R2 release flag
        bus_release();
        chk("R2 rel flag set", rel_flag, 1);
        chk("R2 cmd untouched", cmd_flag, 0);
        wait_ph();
        chk("R2 rel flag sticky", rel_flag, 1);
        pulse(rel_clr);
        chk("R2 rel flag cleared", rel_flag, 0);

        // R3 command flag
        bus_command();
        chk("R3 cmd flag set", cmd_flag, 1);
        chk("R3 rel untouched", rel_flag, 0);
        pulse(cmd_clr);
        chk("R3 cmd flag cleared", cmd_flag, 0);

        // R4 partial byte discarded by a condition
        wake_en = 1'b0;
        bus_release();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_command();
        base = irq_cnt;
        send_byte(8'h15);
        chk("R4 one irq after cut byte", irq_cnt - base, 1);
        chk("R4 byte excludes early bits", rx_byte, 8'h15);

        // R5 / R6 wake-up match then data byte
        wake_en = 1'b1;
        bus_release();
        base = irq_cnt;
        send_byte(own_addr);
        chk("R5 irq on match", irq_cnt - base, 1);
        chk("R5 selected", selected, 1);
        send_byte(8'h3C);
        chk("R6 no irq on data byte", irq_cnt - base, 1);
        chk("R11 data byte", rx_byte, 8'h3C);

        // R6 mismatch
        bus_release();
        base = irq_cnt;
        send_byte(own_addr ^ 8'h01);
        chk("R6 no irq on mismatch", irq_cnt - base, 0);
        chk("R6 not selected", selected, 0);

        // R7 every byte interrupts without wake-up
        wake_en = 1'b0;
        bus_release();
        base = irq_cnt;
        send_byte(8'h00); send_byte(8'hFF); send_byte(8'h81);
        chk("R7 three irqs", irq_cnt - base, 3);
        chk("R11 last byte", rx_byte, 8'h81);

        // R8 / R9 busy drop waits for a clock fall
        scl_m = 1'b0; wait_ph();
        pulse(busy_req);
        chk("R8 pull asserted", sda_pull, 1);
        pulse(busy_drop);
        chk("R8 pending", drop_pending, 1);
        scl_m = 1'b1; wait_ph(); wait_ph();
        chk("R8 still pulled while clock high", sda_pull, 1);
        scl_m = 1'b0; wait_ph();
        chk("R9 released at fall", sda_pull, 0);
        chk("R9 pending cleared", drop_pending, 0);
        chk("R9 line reads ready", sda_line, 1);

        // R10 wake-up set cancels pending drop
        pulse(busy_req);
        pulse(busy_drop);
        chk("R10 pending before wake", drop_pending, 1);
        @(negedge clk); wake_en = 1'b1; wait_ph();
        chk("R10 pending discarded", drop_pending, 0);
        scl_m = 1'b1; wait_ph(); scl_m = 1'b0; wait_ph();
        chk("R10 line stays busy", sda_pull, 1);
        chk("R10 line reads busy", sda_line, 0);
        pulse(busy_drop);
        scl_m = 1'b1; wait_ph(); scl_m = 1'b0; wait_ph();
        chk("R10 release after new drop", sda_pull, 0);
        scl_m = 1'b1; wait_ph();
        pulse(rel_clr); pulse(cmd_clr);

        // Random transactions: R5 R6 R7 R11
        for (int t = 0; t < 24; t++) begin
            int nb;
            bit wk;
            wk = $urandom_range(0, 1);
            nb = $urandom_range(1, 3);
            own_addr = $urandom_range(0, 255);
            wake_en = wk;
            wait_ph();
            bus_release();
            base = irq_cnt;
            first = ($urandom_range(0, 1) == 1) ? own_addr : DATA_W'($urandom_range(0, 255));
            last = first;
            send_byte(first);
            chk(wk ? "R5 random selected" : "R7 random selected", selected, int'(first == own_addr));
            for (int b = 1; b < nb; b++) begin
                v = $urandom_range(0, 255);
                send_byte(v);
                last = v;
            end
            chk(wk ? "R6 random irq count" : "R7 random irq count",
                irq_cnt - base, exp_irqs(wk, first, own_addr, nb));
            chk("R11 random byte", rx_byte, last);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule